// File: doc/BRIEF.md
# Split Fetch/Display Plane Control

This block sits between the register interface of a bitplane display and the pixel path. It decodes a 3-bit plane-count field into two counts. One goes to the memory fetch sequencer and one governs the serializer. For each of six planes it holds a 16-bit data register and a 16-bit parallel-to-serial shifter. Every shown plane contributes one bit per pixel clock, most significant bit first.

In normal use the fetch sequencer writes fresh words into the data registers, and a load strobe every 16 pixels moves them into the shifters. The count value 7 is not a legal setting, but it has defined behaviour. In that case the fetch sequencer is told to service 4 planes while the serializer still shows 6. Planes 5 and 6 then draw on data registers that nothing refreshes, so whatever word was last written into them repeats every 16 pixels. Those two registers can still be rewritten through the register port, and a new pattern takes effect at the next load.

Colour lookup and colour-mode logic sit downstream and see the six plane bits unchanged.

Top module: `split_plane_ctl`

## Requirements
- R1: After a clock edge with `rst_n` low, all data registers and shifters are zero, `pix` is 0, and `fetch_planes` and `show_planes` are 0.
- R2: For a plane-count field value c from 0 to 6, `fetch_planes` and `show_planes` both equal c from the cycle after the write.
- R3: For a plane-count field value of 7, `fetch_planes` is 4 and `show_planes` is 6.
- R4: On a clock edge with `load` high, each shown plane's shifter takes its data register word. From the next cycle, `pix[k-1]` for plane k shows bit 15 of that word.
- R5: Between loads, each shifter moves one bit toward the MSB per clock and fills with 0. After 16 cycles without a reload, every plane outputs 0.
- R6: Plane k (k = 1..6) is shown when k ≤ `show_planes` at the load edge. A plane that is not shown loads 0 and outputs 0 for the whole group.
- R7: With count 7 and `load` pulsed every 16 cycles, planes 5 and 6 repeat their unchanged register words in every group.
- R8: A data register write lands at its clock edge. The current group is unaffected. A load on the same edge as the write still takes the old word, and the new word is shown from the following load.
- R9: Address 0 is the mode register, and its bits [2:0] carry the plane count. Bits [15:3] (for example colour-mode selections) do not affect any output. Addresses 1..6 select the data registers of planes 1..6, and address 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 mode, 1..6 plane data |
| wr_data | input | 16 | Write data |
| load | input | 1 | 16-pixel load strobe |
| fetch_planes | output | 3 | Plane count for the fetch sequencer |
| show_planes | output | 3 | Plane count for the serializer |
| pix | output | 6 | One bit per plane, bit k-1 for plane k |

## Verification
The bench builds the block with its defaults: six planes, 16-bit words and a fetch cap of 4. This keeps every plane-count value within a full sweep. All eight counts are driven, with varying upper mode bits. Every pixel of several back-to-back groups is compared against a model computed from the written words. With count 7, rewrites of planes 5 and 6 are placed mid-group and on a load edge, to pin down exactly which group first shows the new pattern.

// File: rtl/spc_pkg.sv
// Shared constants for the split fetch/display plane control.
// Assumes a 3-bit register address with the mode register at 0
// and plane k's data register at address k.
package spc_pkg;
    localparam int ADDR_W    = 3;
    localparam int CNT_W     = 3;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
endpackage

// File: rtl/spc_count_decode.sv
// Decodes the plane-count field into a fetch count and a display count,
// and a per-plane "shown" mask. Counts beyond NUM_PLANES are illegal:
// fetch is capped at FETCH_CAP while all NUM_PLANES planes are shown.
// Assumes 2**CNT_W - 1 >= NUM_PLANES.
module spc_count_decode #(
    parameter int NUM_PLANES = 6,
    parameter int FETCH_CAP  = 4,
    parameter int CNT_W      = 3
) (
    input  logic [CNT_W-1:0]      mode_cnt,
    output logic [CNT_W-1:0]      fetch_cnt,
    output logic [CNT_W-1:0]      show_cnt,
    output logic [NUM_PLANES-1:0] show_mask
);
    localparam logic [CNT_W-1:0] PLANES_C = CNT_W'(NUM_PLANES);
    localparam logic [CNT_W-1:0] CAP_C    = CNT_W'(FETCH_CAP);

    // Split the field: legal values pass through, illegal ones diverge.
    always_comb begin
        if (mode_cnt > PLANES_C) begin
            fetch_cnt = CAP_C;
            show_cnt  = PLANES_C;
        end else begin
            fetch_cnt = mode_cnt;
            show_cnt  = mode_cnt;
        end
    end

    // Plane k (1-based) is shown when its number does not exceed the display count.
    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_mask
        assign show_mask[k] = (CNT_W'(k + 1) <= show_cnt);
    end

    // The fetch side never services more planes than are shown; mask agrees with count.
    always_comb begin
        p_fetch_within_show_r3: assert (fetch_cnt <= show_cnt);
        p_mask_matches_count_r6: assert ($countones(show_mask) == int'(show_cnt));
    end
endmodule

// File: rtl/spc_regfile.sv
// Register file: one mode register (plane-count field in the low bits)
// and one data register per plane. Unmapped addresses are ignored.
// Assumes the fetch sequencer and software share this one write port.
module spc_regfile
    import spc_pkg::*;
#(
    parameter int NUM_PLANES = 6,
    parameter int WORD_W     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [WORD_W-1:0]                    wr_data,
    output logic [CNT_W-1:0]                     mode_cnt,
    output logic [NUM_PLANES-1:0][WORD_W-1:0]    plane_word
);
    // Mode register: only the count field is stored; upper bits belong elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_cnt <= '0;
        else if (wr_en && wr_addr == ADDR_MODE)
            mode_cnt <= wr_data[CNT_W-1:0];
    end

    p_mode_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE) |=> mode_cnt == $past(wr_data[CNT_W-1:0]));

    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k + 1);

        // Plane data register: holds its last written word until rewritten.
        always_ff @(posedge clk) begin
            if (!rst_n)
                plane_word[k] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                plane_word[k] <= wr_data;
        end

        p_word_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MY_ADDR) |=> plane_word[k] == $past(wr_data));

        p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == MY_ADDR) |=> $stable(plane_word[k]));
    end
endmodule

// File: rtl/spc_shifter.sv
// One plane's parallel-to-serial shifter. On load it captures the word
// (or zero when the plane is not shown); otherwise it shifts toward the
// MSB with zero fill. The output is the MSB.
// Assumes one pixel per clock.
module spc_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              plane_on,
    input  logic [WORD_W-1:0] word_in,
    output logic              bit_out
);
    logic [WORD_W-1:0] shreg;

    // Capture on load, otherwise advance one pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= plane_on ? word_in : '0;
        else
            shreg <= {shreg[WORD_W-2:0], 1'b0};
    end

    assign bit_out = shreg[WORD_W-1];

    p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && plane_on) |=> bit_out == $past(word_in[WORD_W-1]));

    p_hidden_plane_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !plane_on) |=> shreg == '0);

    p_shift_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> bit_out == $past(shreg[WORD_W-2]) && shreg[0] == 1'b0);
endmodule

// File: rtl/split_plane_ctl.sv
// Top: register file, count decoder and one shifter per plane.
// The display count gates which planes load data; the fetch count is
// only reported to the fetch sequencer. Assumes load pulses every
// WORD_W cycles for continuous output.
module split_plane_ctl
    import spc_pkg::*;
#(
    parameter int NUM_PLANES = 6,
    parameter int WORD_W     = 16,
    parameter int FETCH_CAP  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  load,
    output logic [CNT_W-1:0]      fetch_planes,
    output logic [CNT_W-1:0]      show_planes,
    output logic [NUM_PLANES-1:0] pix
);
    logic [CNT_W-1:0]                  mode_cnt;
    logic [NUM_PLANES-1:0][WORD_W-1:0] plane_word;
    logic [NUM_PLANES-1:0]             show_mask;

    spc_regfile #(.NUM_PLANES(NUM_PLANES), .WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode_cnt   (mode_cnt),
        .plane_word (plane_word)
    );

    spc_count_decode #(.NUM_PLANES(NUM_PLANES), .FETCH_CAP(FETCH_CAP), .CNT_W(CNT_W)) u_dec (
        .mode_cnt  (mode_cnt),
        .fetch_cnt (fetch_planes),
        .show_cnt  (show_planes),
        .show_mask (show_mask)
    );

    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_shift
        spc_shifter #(.WORD_W(WORD_W)) u_sh (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .plane_on (show_mask[k]),
            .word_in  (plane_word[k]),
            .bit_out  (pix[k])
        );
    end

    p_counts_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pix == '0 && fetch_planes == '0 && show_planes == '0));
endmodule

// File: tb/sim_split_plane_ctl.sv
module sim_split_plane_ctl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        load = 0;
    logic [2:0]  fetch_planes, show_planes;
    logic [5:0]  pix;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] mreg [1:6];
    logic [15:0] latched [1:6];

    always #2 clk = ~clk;

    split_plane_ctl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .fetch_planes(fetch_planes),
        .show_planes(show_planes), .pix(pix));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int show_of(input int c);
        return (c == 7) ? 6 : c;
    endfunction

    function automatic int fetch_of(input int c);
        return (c == 7) ? 4 : c;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (a >= 1 && a <= 6) mreg[a] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Run n back-to-back groups; optionally one write after sample wi of group wg.
    task automatic groups(input int n, input int c, input string req,
                          input int wg, input int wi, input int wk, input logic [15:0] wd);
        bit ld_next, wr_next;
        logic [5:0] exp;
        @(negedge clk);
        load = 1; ld_next = 1; wr_next = 0;
        for (int g = 0; g < n; g++) begin
            for (int i = 0; i < 16; i++) begin
                @(posedge clk);
                if (ld_next)
                    for (int k = 1; k <= 6; k++)
                        latched[k] = (k <= show_of(c)) ? mreg[k] : 16'h0;
                if (wr_next) mreg[wk] = wd;
                @(negedge clk);
                wr_en = 0;
                ld_next = (i == 15 && g < n - 1);
                load = ld_next;
                wr_next = (g == wg && i == wi);
                if (wr_next) begin
                    wr_en = 1; wr_addr = 3'(wk); wr_data = wd;
                end
                for (int k = 1; k <= 6; k++) exp[k-1] = latched[k][15-i];
                check(pix == exp, req, pix, exp);
            end
        end
        @(posedge clk);
        if (wr_next) mreg[wk] = wd;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        for (int k = 1; k <= 6; k++) begin mreg[k] = 0; latched[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix == 0, "R1 pix", pix, 0);
        check(fetch_planes == 0 && show_planes == 0, "R1 counts",
              {fetch_planes, show_planes}, 0);
        rst_n = 1;
        for (int c = 0; c < 8; c++) begin
            // R9: upper mode bits carry junk that must not matter
            wr(3'd0, {13'(16'h1ABC * (c + 1)), 3'(c)});
            check(int'(fetch_planes) == fetch_of(c), c == 7 ? "R3 fetch" : "R2 fetch",
                  fetch_planes, fetch_of(c));
            check(int'(show_planes) == show_of(c), c == 7 ? "R3 show" : "R2 show",
                  show_planes, show_of(c));
            for (int k = 1; k <= 6; k++)
                wr(3'(k), 16'(32'hA5C3 ^ (k * 32'h1357) ^ (c * 32'h0F1E)));
            wr(3'd7, 16'hFFFF);   // R9: unmapped address ignored
            groups(3, c, c == 7 ? "R7 repeat" : "R4 R6 group", -1, 0, 1, 16'h0);
            check(pix == 0, "R5 zero fill", pix, 0);
        end
        // count still 7: rewrite plane 5 mid-group and plane 6 on a load edge
        groups(4, 7, "R8 mid-group rewrite", 1, 6, 5, 16'h0F0F);
        groups(4, 7, "R8 rewrite at load", 0, 15, 6, 16'hC3A5);
        groups(2, 7, "R7 static repeat", -1, 0, 1, 16'h0);
        finished = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule